// File: doc/BRIEF.md
# Pole-Independent Hysteresis Field Switch

This block turns a stream of signed magnetic flux samples into one switch decision that does not care which magnet pole faces the sensor. A south field stronger than the south operate threshold, or a north field (a negative reading) beyond the north operate threshold, switches it on. It stays on until the field weakens past the release threshold of the pole that is holding it. Each pole has its own hysteresis band, so a reading that wanders near a threshold does not make the output chatter.

Samples arrive from separate front-end and timing logic as 16-bit two's-complement values in gauss, each with a one-cycle valid strobe. The state advances only on valid cycles and otherwise keeps its last decision. Two parameters shape the pin. One chooses the normal or the inverted variant. The other chooses active-low, open-drain-style encoding or active-high encoding. The four thresholds are signed parameters. Elaboration is refused unless each release threshold lies strictly between zero and the operate threshold of its pole.

Top module: `pole_hyst_switch`

## Requirements
- R1: From the off state, a valid sample strictly greater than the south operate threshold (default +37) turns the switch on; a sample equal to it, or anywhere from the north operate threshold up to the south operate threshold, leaves it off.
- R2: From the off state, a valid sample strictly less than the north operate threshold (default -40) turns the switch on; a sample equal to it leaves it off.
- R3: While held on by the south pole, the switch stays on for samples at or above the south release threshold (default +31) and turns off on a valid sample below it, unless that sample is also beyond the north operate threshold.
- R4: While held on by the north pole, the switch stays on for samples at or below the north release threshold (default -34) and turns off on a valid sample above it, unless that sample is also beyond the south operate threshold.
- R5: A valid sample that jumps from one pole's on region past the other pole's operate threshold keeps the switch on, and the release rule of the new pole applies from then on.
- R6: On a cycle with the valid strobe low, the decision does not change, whatever the flux input carries.
- R7: Asserting the active-low reset forces the switch off at once, without waiting for a clock edge.
- R8: `sw_on_o` is 1 while the field decision is on and changes on the clock edge that samples the deciding valid input; in the normal variant with active-low encoding (the defaults), `sw_pin_o` is 0 when on and 1 when off.
- R9: The inverted variant (INVERT = 1) drives `sw_pin_o` to the opposite level of the normal variant for the same sample history, while `sw_on_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; release synchronized upstream |
| flux_vld_i | input | 1 | Flux sample valid strobe |
| flux_i | input | W (16) | Signed flux sample in gauss, two's complement |
| sw_on_o | output | 1 | Field decision, 1 = a pole is detected |
| sw_pin_o | output | 1 | Encoded output pin level |

## Verification
The bench hits each threshold exactly and one count beyond it. A design that used >= where > is meant would switch on at exactly +37 or -40, and one that used the wrong comparator on release would drop out at exactly +31 or -34. The sequence that matters most is a pole swap followed by a reading of +33. A design that forgot which pole holds the switch would keep the south release rule and stay on, where the correct result is off. It also drives large samples with the strobe low, which a design that ignores the strobe would act on, and it drives the two's-complement extremes, which an unsigned comparison would read as the wrong pole.

// File: rtl/phs_pkg.sv
package phs_pkg;

  // Which pole, if any, currently holds the switch on
  typedef enum logic [1:0] {
    SW_OFF   = 2'd0,
    SW_SOUTH = 2'd1,
    SW_NORTH = 2'd2
  } sw_state_e;

  // Per-pole comparison result
  typedef struct packed {
    logic beyond_op;   // field past the operate threshold of this pole
    logic in_hold;     // field still on the held side of the release threshold
  } pole_cmp_t;

endpackage

// File: rtl/phs_pole_cmp.sv
module phs_pole_cmp
  import phs_pkg::*;
#(
  parameter int unsigned      W     = 16,
  parameter logic signed [W-1:0] OP_TH = 16'sd37,
  parameter logic signed [W-1:0] RL_TH = 16'sd31,
  parameter bit               NORTH = 1'b0
) (
  input  logic signed [W-1:0] flux_i,
  output pole_cmp_t           cmp_o
);

  generate
    if (NORTH) begin : g_north
      // North pole: more negative means stronger
      always_comb begin
        cmp_o.beyond_op = (flux_i <  OP_TH);
        cmp_o.in_hold   = (flux_i <= RL_TH);
      end
    end else begin : g_south
      always_comb begin
        cmp_o.beyond_op = (flux_i >  OP_TH);
        cmp_o.in_hold   = (flux_i >= RL_TH);
      end
    end
  endgenerate

endmodule

// File: rtl/phs_state.sv
module phs_state
  import phs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  pole_cmp_t south_i,
  input  pole_cmp_t north_i,
  output logic      on_o
);

  sw_state_e state_q;
  sw_state_e state_d;

  // Next-state: remember which pole holds so its own release rule applies (R3, R4, R5)
  always_comb begin
    state_d = state_q;
    if (en_i) begin
      unique case (state_q)
        SW_SOUTH: begin
          if (south_i.in_hold)        state_d = SW_SOUTH;
          else if (north_i.beyond_op) state_d = SW_NORTH;
          else                        state_d = SW_OFF;
        end
        SW_NORTH: begin
          if (north_i.in_hold)        state_d = SW_NORTH;
          else if (south_i.beyond_op) state_d = SW_SOUTH;
          else                        state_d = SW_OFF;
        end
        default: begin
          if (south_i.beyond_op)      state_d = SW_SOUTH;
          else if (north_i.beyond_op) state_d = SW_NORTH;
          else                        state_d = SW_OFF;
        end
      endcase
    end
  end

  // Register with asynchronous clear (R7)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_OFF;
    end else begin
      state_q <= state_d;
    end
  end

  assign on_o = (state_q != SW_OFF);

endmodule

// File: rtl/phs_pin_enc.sv
module phs_pin_enc #(
  parameter bit INVERT     = 1'b0,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic on_i,
  output logic pin_o
);

  logic asserted;

  generate
    if (INVERT) begin : g_inv
      assign asserted = ~on_i;
    end else begin : g_norm
      assign asserted = on_i;
    end

    if (ACTIVE_LOW) begin : g_low
      assign pin_o = ~asserted;
    end else begin : g_high
      assign pin_o = asserted;
    end
  endgenerate

endmodule

// File: rtl/pole_hyst_switch.sv
module pole_hyst_switch
  import phs_pkg::*;
#(
  parameter int unsigned         W          = 16,
  parameter logic signed [W-1:0] S_OP       = 16'sd37,
  parameter logic signed [W-1:0] S_RL       = 16'sd31,
  parameter logic signed [W-1:0] N_OP       = -16'sd40,
  parameter logic signed [W-1:0] N_RL       = -16'sd34,
  parameter bit                  INVERT     = 1'b0,
  parameter bit                  ACTIVE_LOW = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flux_vld_i,
  input  logic signed [W-1:0] flux_i,
  output logic                sw_on_o,
  output logic                sw_pin_o
);

  localparam logic signed [W-1:0] ZERO = '0;

  // Threshold ordering checks at elaboration
  generate
    if (!((S_RL > ZERO) && (S_RL < S_OP))) begin : g_bad_south
      $error("south release threshold must lie between zero and south operate threshold");
    end
    if (!((N_RL < ZERO) && (N_RL > N_OP))) begin : g_bad_north
      $error("north release threshold must lie between zero and north operate threshold");
    end
  endgenerate

  pole_cmp_t south_cmp;
  pole_cmp_t north_cmp;

  phs_pole_cmp #(.W(W), .OP_TH(S_OP), .RL_TH(S_RL), .NORTH(1'b0)) u_south (
    .flux_i (flux_i),
    .cmp_o  (south_cmp)
  );

  phs_pole_cmp #(.W(W), .OP_TH(N_OP), .RL_TH(N_RL), .NORTH(1'b1)) u_north (
    .flux_i (flux_i),
    .cmp_o  (north_cmp)
  );

  phs_state u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (flux_vld_i),
    .south_i (south_cmp),
    .north_i (north_cmp),
    .on_o    (sw_on_o)
  );

  phs_pin_enc #(.INVERT(INVERT), .ACTIVE_LOW(ACTIVE_LOW)) u_enc (
    .on_i  (sw_on_o),
    .pin_o (sw_pin_o)
  );

endmodule

// File: rtl/pole_hyst_switch_chk.sv
module pole_hyst_switch_chk #(
  parameter int unsigned         W    = 16,
  parameter logic signed [W-1:0] S_OP = 16'sd37,
  parameter logic signed [W-1:0] S_RL = 16'sd31,
  parameter logic signed [W-1:0] N_OP = -16'sd40,
  parameter logic signed [W-1:0] N_RL = -16'sd34
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                flux_vld_i,
  input logic signed [W-1:0] flux_i,
  input logic                sw_on_o
);

  assert_south_operate_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flux_vld_i && !sw_on_o && (flux_i > S_OP)) |=> sw_on_o);

  assert_quiet_stays_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flux_vld_i && !sw_on_o && (flux_i >= N_OP) && (flux_i <= S_OP)) |=> !sw_on_o);

  assert_north_operate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flux_vld_i && !sw_on_o && (flux_i < N_OP)) |=> sw_on_o);

  // Between both release thresholds either holding pole lets go (R3, R4)
  assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flux_vld_i && sw_on_o && (flux_i > N_RL) && (flux_i < S_RL)) |=> !sw_on_o);

  assert_hold_no_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flux_vld_i |=> $stable(sw_on_o));

endmodule

bind pole_hyst_switch pole_hyst_switch_chk #(
  .W(W), .S_OP(S_OP), .S_RL(S_RL), .N_OP(N_OP), .N_RL(N_RL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flux_vld_i (flux_vld_i),
  .flux_i     (flux_i),
  .sw_on_o    (sw_on_o)
);

// File: tb/tb_pole_hyst_switch.sv
module tb_pole_hyst_switch;

  localparam int NV = 19;

  logic               clk;
  logic               rst_n;
  logic               vld;
  logic signed [15:0] flux;
  logic               on_n, pin_n, on_i, pin_i;
  int                 checks = 0;
  int                 fails  = 0;
  bit                 done   = 0;

  // Vector table: flux, valid, expected decision, requirement number
  localparam logic signed [15:0] V_FLUX [NV] = '{
    16'sd0, 16'sd37, 16'sd38, 16'sd31, 16'sd20, 16'sd30, 16'sd36,
    -16'sd40, -16'sd41, -16'sd34, -16'sd33, 16'sd100, -16'sd60,
    -16'sd36, 16'sd33, -16'sd100, -16'sd32768, 16'sd32767, 16'sd0};
  localparam bit V_VLD [NV] = '{1,1,1,1,0,1,1, 1,1,1,1,1,1, 1,1,0,1,1,1};
  localparam bit V_ON  [NV] = '{0,0,1,1,1,0,0, 0,1,1,0,1,1, 1,0,0,1,1,0};
  // R1 R1 R1 R3 R6 R3 R1 | R2 R2 R4 R4 R1 R5 | R5 R5 R6 R2 R5 R3
  localparam int V_REQ [NV] = '{1,1,1,3,6,3,1, 2,2,4,4,1,5, 5,5,6,2,5,3};

  pole_hyst_switch dut (
    .clk_i(clk), .rst_ni(rst_n), .flux_vld_i(vld), .flux_i(flux),
    .sw_on_o(on_n), .sw_pin_o(pin_n));

  pole_hyst_switch #(.INVERT(1'b1)) dut_inv (
    .clk_i(clk), .rst_ni(rst_n), .flux_vld_i(vld), .flux_i(flux),
    .sw_on_o(on_i), .sw_pin_o(pin_i));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Check decision and both pin encodings against one expected decision
  task automatic chk_all(input string req, input logic exp_on);
    chk(req, on_n, exp_on);
    chk("R8 pin", pin_n, ~exp_on);   // R8: active low, normal
    chk("R9 inverted pin", pin_i, exp_on);  // R9: inverted variant
    chk("R9 decision", on_i, exp_on);
  endtask

  initial begin
    rst_n = 1'b0;
    vld   = 1'b0;
    flux  = '0;
    repeat (3) @(negedge clk);
    chk_all("R7 reset state", 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vld  = V_VLD[i];
      flux = V_FLUX[i];
      @(negedge clk);
      chk_all($sformatf("R%0d vec %0d", V_REQ[i], i), V_ON[i]);
    end

    // R7: asynchronous clear while on
    vld = 1'b1; flux = 16'sd90;
    @(negedge clk);
    chk_all("R1 before reset", 1'b1);
    vld = 1'b0;
    #3 rst_n = 1'b0;
    #1 chk_all("R7 async clear", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R7 stays off after release", 1'b0);

    // R6: strong north sample without strobe after reset
    flux = -16'sd200;
    @(negedge clk);
    chk_all("R6 ignored north", 1'b0);

    // R4: north hold near release boundary, then R2 extreme
    vld = 1'b1; flux = -16'sd41;
    @(negedge clk);
    chk_all("R2 on", 1'b1);
    flux = -16'sd35;
    @(negedge clk);
    chk_all("R4 hold", 1'b1);
    flux = 16'sd38;
    @(negedge clk);
    chk_all("R4 swap to south", 1'b1);
    flux = 16'sd31;
    @(negedge clk);
    chk_all("R3 hold at release", 1'b1);
    vld = 1'b0;

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule